// File: doc/BRIEF.md
# I2C Target Byte Engine with Masked Address Match

This block is the receive and transmit byte engine of a 7-bit-address I2C target. It runs entirely in the system clock domain. SCL and SDA pass through synchronisers, and the block watches them for start and stop conditions. After a start it shifts in an address byte and compares bits 7:1 of that byte with a programmable own address. A five-bit mask can turn selected address bits into don't-cares, so a single target can answer a group of addresses. The block drives both lines only as open-drain pull-low enables; the pads and pull-ups sit outside it.

A completed byte goes into a receive buffer and raises a buffer-full flag. An interrupt flag is set on the falling edge of the ninth clock. If the buffer is still full, or the overflow flag is still set, the engine withholds the acknowledge, keeps the old buffer contents and sets the overflow flag. The engine can stretch the clock after each written byte, and it always stretches after a read address and after each acknowledged read byte. Software ends a stretch by setting a release bit; the engine clears that bit itself when the next stretch begins. Software uses a simple strobe port with write and read strobes.

The engine moves through these states:

- IDLE: waiting for a start.
- ADDR: shifting in the address byte.
- ACK: the ninth clock of a received byte, with SDA held low or released.
- RX: shifting in a data byte.
- HOLD: holding SCL low.
- TX: shifting out a read byte.
- MACK: waiting for the master's acknowledge bit.
- MDONE: after the master has acknowledged, waiting for the ninth falling edge.

The transitions are:

- Any state goes to ADDR on a start, and to IDLE on a stop.
- ADDR goes to IDLE when the address does not match. On a match it goes to ACK at the eighth falling edge.
- RX goes to ACK at its eighth falling edge.
- ACK goes on at the ninth falling edge:
  - to IDLE after a withheld address acknowledge;
  - to HOLD for a read, or for a write with stretching on;
  - otherwise to RX.
- HOLD goes to TX or RX once the release bit is set.
- TX goes to MACK at its eighth falling edge.
- MACK goes to IDLE on a master NACK, and to MDONE on a master ACK.
- MDONE goes to HOLD at the ninth falling edge.

Top module: `i2c_mask_slave`

## Requirements
- R1: After reset, neither SCL nor SDA is pulled low, the irq output is 0, and the status register (offset 4) reads 0.
- R2: When address bits 7:1 match the own address (offset 1, bits 7:1), the engine pulls SDA low during the ninth SCL high phase. It also copies the byte into the receive buffer (offset 0) and sets status bit 0 (full); status bit 3 takes the byte's bit 0 (R/W). Data bytes that follow in a write are stored and acknowledged in the same way.
- R3: Each set bit n of the mask register (offset 2, bits 4:0) makes address bit n+1 a don't-care. With own address 0xA0 and mask 0x07, the bytes 0xA0, 0xA2, 0xA4 and so on up to 0xAE are acknowledged, and 0xB0, 0x80 and 0xE0 are not.
- R4: The interrupt flag (status bit 2, also driven on irq) is still 0 while the ninth SCL is high, and becomes 1 after the ninth SCL falling edge.
- R5: When full or overflow (status bit 1) is already set as a byte completes, the engine releases SDA on the ninth clock and leaves the buffer unchanged. It sets the overflow flag and still sets the interrupt flag.
- R6: Reading offset 0 clears full but leaves overflow and interrupt set. Writing 1 to status bits 1 and 2 clears them.
- R7: When control bit 0 (stretch enable, offset 3) is set, SCL stays low after each received byte until control bit 1 (release) is written 1. Release reads back 0 once a stretch has begun.
- R8: When stretch enable is 0, SCL is not held after an acknowledged write byte.
- R9: After a matched address with R/W=1, SCL is held whatever the stretch enable. After release, the byte written to offset 0 is shifted out MSB first.
- R10: A master ACK on a read byte leads to another stretch and the next byte from offset 0. A master NACK returns the engine to idle with no stretch and clears full and R/W.
- R11: After a stop, clocked bits without a new start are ignored: no acknowledge, no flag change.
- R12: An address that does not match, and any data bits that follow it, get no acknowledge and set no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | SCL level as seen at the pad |
| sda_i | input | 1 | SDA level as seen at the pad |
| scl_pull_o | output | 1 | 1 pulls SCL low (clock stretch) |
| sda_pull_o | output | 1 | 1 pulls SDA low |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe (side effects apply on this cycle) |
| reg_addr_i | input | 3 | Register offset |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data (combinational from offset) |
| irq_o | output | 1 | Interrupt flag |

## Verification
Every bus edge reaches the engine three clock cycles after it appears on the pad: two synchroniser flops, then one state register. So the acknowledge level, the flags and the SCL hold all change within four cycles of the SCL edge that causes them. The bench samples the acknowledge in the middle of a high phase of eight cycles, and checks flags and SCL hold eight cycles after the falling edge. All register writes and all samples happen on the falling clock edge. A release write takes effect two edges after its strobe, so the check for a dropped SCL hold waits four cycles.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ACK,
        ST_RX,
        ST_HOLD,
        ST_TX,
        ST_MACK,
        ST_MDONE
    } i2cs_state_e;

    localparam logic [2:0] RA_DATA = 3'd0;
    localparam logic [2:0] RA_OWN  = 3'd1;
    localparam logic [2:0] RA_MASK = 3'd2;
    localparam logic [2:0] RA_CTRL = 3'd3;
    localparam logic [2:0] RA_STAT = 3'd4;
endpackage

// File: rtl/i2cs_line_cond.sv
module i2cs_line_cond #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_rise_o,
    output logic scl_fall_o,
    output logic sda_o,
    output logic start_o,
    output logic stop_o
);
    // bit 1 = SCL, bit 0 = SDA; idle bus is high
    logic [STAGES-1:0][1:0] pipe;
    logic [1:0] cur, prev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pipe <= '1;
            prev <= '1;
        end else begin
            pipe[0] <= {scl_i, sda_i};
            for (int k = 1; k < STAGES; k++) pipe[k] <= pipe[k-1];
            prev <= pipe[STAGES-1];
        end
    end

    assign cur        = pipe[STAGES-1];
    assign scl_rise_o = cur[1] & ~prev[1];
    assign scl_fall_o = ~cur[1] & prev[1];
    assign sda_o      = cur[0];
    assign start_o    = cur[1] & prev[1] & prev[0] & ~cur[0];
    assign stop_o     = cur[1] & prev[1] & ~prev[0] & cur[0];
endmodule

// File: rtl/i2cs_addr_cmp.sv
module i2cs_addr_cmp #(
    parameter int AW = 7,
    parameter int MW = 5
) (
    input  logic [AW-1:0] rx_addr_i,
    input  logic [AW-1:0] own_addr_i,
    input  logic [MW-1:0] mask_i,
    output logic          hit_o
);
    logic [AW-1:0] ok;

    for (genvar i = 0; i < AW; i++) begin : g_bit
        if (i < MW) begin : g_masked
            assign ok[i] = mask_i[i] | (rx_addr_i[i] == own_addr_i[i]);
        end else begin : g_plain
            assign ok[i] = (rx_addr_i[i] == own_addr_i[i]);
        end
    end

    assign hit_o = &ok;
endmodule

// File: rtl/i2cs_engine.sv
module i2cs_engine
    import i2cs_pkg::*;
#(
    parameter int BITS = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            scl_rise_i,
    input  logic            scl_fall_i,
    input  logic            sda_i,
    input  logic            start_i,
    input  logic            stop_i,
    input  logic            addr_hit_i,
    input  logic            full_i,
    input  logic            ovf_i,
    input  logic            stretch_en_i,
    input  logic            release_i,
    input  logic [BITS-1:0] tx_data_i,
    output logic [BITS-1:0] shift_o,
    output logic            rw_o,
    output logic            ev_store_o,
    output logic            ev_ovf_o,
    output logic            ev_irq_o,
    output logic            ev_nack_end_o,
    output logic            ev_stretch_o,
    output logic            scl_pull_o,
    output logic            sda_pull_o,
    output i2cs_state_e     state_o
);
    localparam int CW = $clog2(BITS + 1);
    localparam logic [CW-1:0] LAST_RX = CW'(BITS);
    localparam logic [CW-1:0] LAST_TX = CW'(BITS - 1);

    i2cs_state_e     state, nxt;
    logic [CW-1:0]   cnt;
    logic [BITS-1:0] rx_sr, tx_sr;
    logic            ack_q, abort_q, rw_q;
    logic            ev_addr;

    // next state and event strobes
    always_comb begin
        nxt           = state;
        ev_store_o    = 1'b0;
        ev_addr       = 1'b0;
        ev_ovf_o      = 1'b0;
        ev_irq_o      = 1'b0;
        ev_nack_end_o = 1'b0;
        ev_stretch_o  = 1'b0;
        if (stop_i) begin
            nxt = ST_IDLE;
        end else if (start_i) begin
            nxt = ST_ADDR;
        end else begin
            unique case (state)
                ST_IDLE: ;
                ST_ADDR: if (scl_fall_i && cnt == LAST_RX) begin
                    if (!addr_hit_i) begin
                        nxt = ST_IDLE;
                    end else if (full_i || ovf_i) begin
                        ev_ovf_o = 1'b1;
                        nxt      = ST_ACK;
                    end else begin
                        ev_store_o = 1'b1;
                        ev_addr    = 1'b1;
                        nxt        = ST_ACK;
                    end
                end
                ST_RX: if (scl_fall_i && cnt == LAST_RX) begin
                    if (full_i || ovf_i) ev_ovf_o = 1'b1;
                    else                 ev_store_o = 1'b1;
                    nxt = ST_ACK;
                end
                ST_ACK: if (scl_fall_i) begin
                    ev_irq_o = 1'b1;
                    if (abort_q) begin
                        nxt = ST_IDLE;
                    end else if (rw_q || stretch_en_i) begin
                        nxt          = ST_HOLD;
                        ev_stretch_o = 1'b1;
                    end else begin
                        nxt = ST_RX;
                    end
                end
                ST_HOLD: if (release_i) nxt = rw_q ? ST_TX : ST_RX;
                ST_TX: if (scl_fall_i && cnt == LAST_TX) nxt = ST_MACK;
                ST_MACK: if (scl_rise_i) begin
                    if (sda_i) begin
                        ev_nack_end_o = 1'b1;
                        nxt           = ST_IDLE;
                    end else begin
                        nxt = ST_MDONE;
                    end
                end
                ST_MDONE: if (scl_fall_i) begin
                    ev_irq_o     = 1'b1;
                    ev_stretch_o = 1'b1;
                    nxt          = ST_HOLD;
                end
                default: nxt = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // datapath: counters and shift registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt     <= '0;
            rx_sr   <= '0;
            tx_sr   <= '1;
            ack_q   <= 1'b0;
            abort_q <= 1'b0;
            rw_q    <= 1'b0;
        end else begin
            if (start_i || nxt != state)
                cnt <= '0;
            else if ((state == ST_ADDR || state == ST_RX) && scl_rise_i)
                cnt <= cnt + 1'b1;
            else if (state == ST_TX && scl_fall_i)
                cnt <= cnt + 1'b1;

            if ((state == ST_ADDR || state == ST_RX) && scl_rise_i)
                rx_sr <= {rx_sr[BITS-2:0], sda_i};

            if (nxt == ST_ACK && state != ST_ACK) begin
                ack_q   <= ev_store_o;
                abort_q <= (state == ST_ADDR) && !ev_store_o;
            end

            if (ev_addr)            rw_q <= rx_sr[0];
            else if (ev_nack_end_o) rw_q <= 1'b0;

            if (nxt == ST_TX && state != ST_TX)
                tx_sr <= tx_data_i;
            else if (state == ST_TX && scl_fall_i)
                tx_sr <= {tx_sr[BITS-2:0], 1'b1};
        end
    end

    // outputs
    always_comb begin
        scl_pull_o = (state == ST_HOLD);
        sda_pull_o = ((state == ST_ACK) && ack_q) ||
                     ((state == ST_TX) && !tx_sr[BITS-1]);
        shift_o    = rx_sr;
        rw_o       = rw_q;
        state_o    = state;
    end
endmodule

// File: rtl/i2c_mask_slave.sv
module i2c_mask_slave
    import i2cs_pkg::*;
#(
    parameter int DW          = 8,
    parameter int MW          = 5,
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          scl_i,
    input  logic          sda_i,
    output logic          scl_pull_o,
    output logic          sda_pull_o,
    input  logic          reg_wr_i,
    input  logic          reg_rd_i,
    input  logic [2:0]    reg_addr_i,
    input  logic [DW-1:0] reg_wdata_i,
    output logic [DW-1:0] reg_rdata_o,
    output logic          irq_o
);
    localparam int AW = DW - 1;

    logic scl_rise, scl_fall, sda_now, start_ev, stop_ev;
    logic addr_hit;
    logic [DW-1:0] shift_val;
    logic eng_rw, ev_store, ev_ovf, ev_irq, ev_nack_end, ev_stretch;
    i2cs_state_e eng_state;

    logic [DW-1:0] rxbuf_q, tx_q;
    logic [AW-1:0] own_q;
    logic [MW-1:0] mask_q;
    logic stretch_q, release_q, full_q, ovf_q, irq_q;

    logic data_rd, data_wr, own_wr, mask_wr, ctrl_wr, stat_wr;
    assign data_rd = reg_rd_i && reg_addr_i == RA_DATA;
    assign data_wr = reg_wr_i && reg_addr_i == RA_DATA;
    assign own_wr  = reg_wr_i && reg_addr_i == RA_OWN;
    assign mask_wr = reg_wr_i && reg_addr_i == RA_MASK;
    assign ctrl_wr = reg_wr_i && reg_addr_i == RA_CTRL;
    assign stat_wr = reg_wr_i && reg_addr_i == RA_STAT;

    i2cs_line_cond #(.STAGES(SYNC_STAGES)) u_cond (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .scl_rise_o(scl_rise), .scl_fall_o(scl_fall), .sda_o(sda_now),
        .start_o(start_ev), .stop_o(stop_ev)
    );

    i2cs_addr_cmp #(.AW(AW), .MW(MW)) u_cmp (
        .rx_addr_i(shift_val[DW-1:1]), .own_addr_i(own_q),
        .mask_i(mask_q), .hit_o(addr_hit)
    );

    i2cs_engine #(.BITS(DW)) u_eng (
        .clk(clk), .rst_n(rst_n),
        .scl_rise_i(scl_rise), .scl_fall_i(scl_fall), .sda_i(sda_now),
        .start_i(start_ev), .stop_i(stop_ev), .addr_hit_i(addr_hit),
        .full_i(full_q), .ovf_i(ovf_q), .stretch_en_i(stretch_q),
        .release_i(release_q), .tx_data_i(tx_q),
        .shift_o(shift_val), .rw_o(eng_rw),
        .ev_store_o(ev_store), .ev_ovf_o(ev_ovf), .ev_irq_o(ev_irq),
        .ev_nack_end_o(ev_nack_end), .ev_stretch_o(ev_stretch),
        .scl_pull_o(scl_pull_o), .sda_pull_o(sda_pull_o),
        .state_o(eng_state)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rxbuf_q   <= '0;
            tx_q      <= '1;
            own_q     <= '0;
            mask_q    <= '0;
            stretch_q <= 1'b0;
            release_q <= 1'b0;
            full_q    <= 1'b0;
            ovf_q     <= 1'b0;
            irq_q     <= 1'b0;
        end else begin
            if (data_wr) tx_q   <= reg_wdata_i;
            if (own_wr)  own_q  <= reg_wdata_i[DW-1:1];
            if (mask_wr) mask_q <= reg_wdata_i[MW-1:0];
            if (ctrl_wr) stretch_q <= reg_wdata_i[0];

            if (ctrl_wr && reg_wdata_i[1]) release_q <= 1'b1;
            else if (ev_stretch)           release_q <= 1'b0;

            if (ev_store) rxbuf_q <= shift_val;

            if (ev_store)                    full_q <= 1'b1;
            else if (data_rd || ev_nack_end) full_q <= 1'b0;

            if (ev_ovf)                          ovf_q <= 1'b1;
            else if (stat_wr && reg_wdata_i[1])  ovf_q <= 1'b0;

            if (ev_irq)                          irq_q <= 1'b1;
            else if (stat_wr && reg_wdata_i[2])  irq_q <= 1'b0;
        end
    end

    always_comb begin
        unique case (reg_addr_i)
            RA_DATA: reg_rdata_o = rxbuf_q;
            RA_OWN:  reg_rdata_o = {own_q, 1'b0};
            RA_MASK: reg_rdata_o = DW'(mask_q);
            RA_CTRL: reg_rdata_o = DW'({release_q, stretch_q});
            RA_STAT: reg_rdata_o = DW'({eng_rw, irq_q, ovf_q, full_q});
            default: reg_rdata_o = '0;
        endcase
    end

    assign irq_o = irq_q;
endmodule

// File: rtl/i2cs_checker.sv
module i2cs_checker
    import i2cs_pkg::*;
#(
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          full_q,
    input logic          ovf_q,
    input logic          irq_q,
    input logic [DW-1:0] rxbuf_q,
    input logic          release_q,
    input logic          scl_fall,
    input logic          scl_pull_o,
    input logic          data_rd,
    input logic          stat_wr,
    input logic [DW-1:0] reg_wdata_i,
    input i2cs_state_e   eng_state
);
    // R5: a full buffer is never overwritten
    a_r5_keep_full_buffer: assert property (@(posedge clk) disable iff (!rst_n)
        (full_q && !data_rd) |=> $stable(rxbuf_q));

    // R6: overflow only clears by a status write
    a_r6_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_q && !(stat_wr && reg_wdata_i[1])) |=> ovf_q);

    // R6: interrupt only clears by a status write
    a_r6_irq_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_q && !(stat_wr && reg_wdata_i[2])) |=> irq_q);

    // R4: interrupt rises only right after an SCL falling edge
    a_r4_irq_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_q) |-> $past(scl_fall));

    // R7: a set release bit ends the stretch on the next cycle
    a_r7_release_ends_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_state == ST_HOLD && release_q) |=> !scl_pull_o);
endmodule

bind i2c_mask_slave i2cs_checker #(.DW(DW)) u_chk (
    .clk(clk), .rst_n(rst_n), .full_q(full_q), .ovf_q(ovf_q),
    .irq_q(irq_q), .rxbuf_q(rxbuf_q), .release_q(release_q),
    .scl_fall(scl_fall), .scl_pull_o(scl_pull_o), .data_rd(data_rd),
    .stat_wr(stat_wr), .reg_wdata_i(reg_wdata_i), .eng_state(eng_state)
);

// File: tb/sim_i2c_mask_slave.sv
`timescale 1ns/1ps
module sim_i2c_mask_slave;
    localparam int HP = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic m_scl_low = 1'b0;
    logic m_sda_low = 1'b0;
    logic scl_bus, sda_bus;
    logic scl_pull, sda_pull, irq;
    logic reg_wr = 1'b0, reg_rd = 1'b0;
    logic [2:0] reg_addr = 3'd0;
    logic [7:0] reg_wdata = 8'd0, reg_rdata;
    int n_chk = 0, n_bad = 0;
    bit done = 0;

    always #4 clk = ~clk;

    assign scl_bus = ~(m_scl_low | scl_pull);
    assign sda_bus = ~(m_sda_low | sda_pull);

    i2c_mask_slave u0 (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_bus), .sda_i(sda_bus),
        .scl_pull_o(scl_pull), .sda_pull_o(sda_pull),
        .reg_wr_i(reg_wr), .reg_rd_i(reg_rd), .reg_addr_i(reg_addr),
        .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata), .irq_o(irq)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic reg_write(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic reg_read(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_rd = 1'b1;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic wait_scl_high();
        wait_cyc(1);
        while (!scl_bus) @(negedge clk);
    endtask

    task automatic bit_xfer(input logic b, output logic seen);
        m_sda_low = ~b;
        wait_cyc(HP);
        m_scl_low = 1'b0;
        wait_scl_high();
        wait_cyc(HP/2);
        seen = sda_bus;
        wait_cyc(HP/2);
        m_scl_low = 1'b1;
    endtask

    task automatic bus_start();
        m_sda_low = 1'b0;
        wait_cyc(HP);
        m_scl_low = 1'b0;
        wait_scl_high();
        wait_cyc(HP);
        m_sda_low = 1'b1;
        wait_cyc(HP);
        m_scl_low = 1'b1;
        wait_cyc(HP);
    endtask

    task automatic bus_stop();
        m_sda_low = 1'b1;
        wait_cyc(HP);
        m_scl_low = 1'b0;
        wait_scl_high();
        wait_cyc(HP);
        m_sda_low = 1'b0;
        wait_cyc(HP);
    endtask

    task automatic send_byte(input logic [7:0] v, output logic acked);
        logic s;
        for (int i = 7; i >= 0; i--) bit_xfer(v[i], s);
        bit_xfer(1'b1, s);
        acked = ~s;
    endtask

    task automatic recv_byte(input logic give_ack, output logic [7:0] v);
        logic s;
        v = '0;
        for (int i = 0; i < 8; i++) begin
            bit_xfer(1'b1, s);
            v = {v[6:0], s};
        end
        bit_xfer(~give_ack, s);
    endtask

    task automatic t_reset();
        logic [7:0] d;
        reg_read(3'd4, d);
        chk("R1", "status after reset", d, 0);
        chk("R1", "scl pull after reset", scl_pull, 0);
        chk("R1", "sda pull after reset", sda_pull, 0);
        chk("R1", "irq after reset", irq, 0);
    endtask

    task automatic t_write_basic();
        logic [7:0] d;
        logic s, a;
        reg_write(3'd1, 8'hA0);
        reg_write(3'd2, 8'h00);
        reg_write(3'd3, 8'h00);
        bus_start();
        for (int i = 7; i >= 0; i--) bit_xfer(((8'hA0 >> i) & 1) != 0, s);
        m_sda_low = 1'b0;
        wait_cyc(HP);
        m_scl_low = 1'b0;
        wait_scl_high();
        wait_cyc(HP/2);
        chk("R2", "ack level on ninth clock", sda_bus, 0);
        chk("R4", "irq before ninth fall", irq, 0);
        wait_cyc(HP/2);
        m_scl_low = 1'b1;
        wait_cyc(HP);
        chk("R4", "irq after ninth fall", irq, 1);
        chk("R8", "no hold with stretch off", scl_pull, 0);
        reg_read(3'd4, d);
        chk("R2", "status full, write", d, 8'h05);
        reg_read(3'd0, d);
        chk("R2", "buffer holds address", d, 8'hA0);
        reg_read(3'd4, d);
        chk("R6", "read clears full only", d, 8'h04);
        reg_write(3'd4, 8'h04);
        reg_read(3'd4, d);
        chk("R6", "irq cleared by write", d, 8'h00);
        send_byte(8'h3C, a);
        chk("R2", "data byte ack", a, 1);
        wait_cyc(HP);
        reg_read(3'd0, d);
        chk("R2", "data byte stored", d, 8'h3C);
        reg_write(3'd4, 8'h06);
        bus_stop();
    endtask

    task automatic t_overflow();
        logic [7:0] d;
        logic a;
        bus_start();
        send_byte(8'hA0, a);
        chk("R5", "address ack before overflow", a, 1);
        send_byte(8'h55, a);
        chk("R5", "nack on full buffer", a, 0);
        wait_cyc(HP);
        reg_read(3'd4, d);
        chk("R5", "status full+ovf+irq", d, 8'h07);
        reg_read(3'd0, d);
        chk("R5", "buffer not overwritten", d, 8'hA0);
        reg_read(3'd4, d);
        chk("R6", "ovf and irq survive read", d, 8'h06);
        send_byte(8'h66, a);
        chk("R5", "nack while ovf set", a, 0);
        wait_cyc(HP);
        reg_read(3'd4, d);
        chk("R5", "byte not stored under ovf", d, 8'h06);
        reg_write(3'd4, 8'h06);
        reg_read(3'd4, d);
        chk("R6", "ovf and irq cleared by write", d, 8'h00);
        bus_stop();
    endtask

    task automatic t_mask();
        logic [7:0] d;
        logic a;
        logic [7:0] miss [3] = '{8'hB0, 8'h80, 8'hE0};
        reg_write(3'd1, 8'hA0);
        reg_write(3'd2, 8'h07);
        for (int k = 0; k < 8; k++) begin
            bus_start();
            send_byte(8'(8'hA0 + 2 * k), a);
            chk("R3", "masked address ack", a, 1);
            wait_cyc(HP);
            reg_read(3'd0, d);
            chk("R3", "masked address stored", d, 8'hA0 + 2 * k);
            reg_write(3'd4, 8'h06);
            bus_stop();
        end
        for (int k = 0; k < 3; k++) begin
            bus_start();
            send_byte(miss[k], a);
            chk("R3", "unmasked bit mismatch nack", a, 0);
            wait_cyc(HP);
            chk("R3", "no irq on mismatch", irq, 0);
            bus_stop();
        end
        reg_write(3'd2, 8'h00);
    endtask

    task automatic t_mismatch();
        logic [7:0] d;
        logic a;
        bus_start();
        send_byte(8'hA2, a);
        chk("R12", "mismatch nack", a, 0);
        send_byte(8'hA0, a);
        chk("R12", "following data ignored", a, 0);
        wait_cyc(HP);
        reg_read(3'd4, d);
        chk("R12", "no flags after mismatch", d, 8'h00);
        bus_stop();
    endtask

    task automatic t_stop();
        logic [7:0] d;
        logic a;
        bus_start();
        send_byte(8'hA0, a);
        chk("R11", "ack before stop", a, 1);
        wait_cyc(HP);
        reg_read(3'd0, d);
        reg_write(3'd4, 8'h06);
        bus_stop();
        send_byte(8'hA0, a);
        chk("R11", "no ack without start", a, 0);
        wait_cyc(HP);
        reg_read(3'd4, d);
        chk("R11", "no flags without start", d, 8'h00);
        bus_stop();
    endtask

    task automatic t_stretch();
        logic [7:0] d;
        logic a;
        reg_write(3'd3, 8'h03);
        bus_start();
        send_byte(8'hA0, a);
        chk("R7", "address ack", a, 1);
        wait_cyc(HP);
        chk("R7", "scl held after byte", scl_pull, 1);
        reg_read(3'd3, d);
        chk("R7", "release auto cleared", d, 8'h01);
        wait_cyc(30);
        chk("R7", "scl still held", scl_pull, 1);
        reg_read(3'd0, d);
        reg_write(3'd4, 8'h04);
        reg_write(3'd3, 8'h03);
        wait_cyc(4);
        chk("R7", "release drops hold", scl_pull, 0);
        send_byte(8'h81, a);
        chk("R7", "data ack", a, 1);
        wait_cyc(HP);
        chk("R7", "scl held after data", scl_pull, 1);
        reg_read(3'd0, d);
        chk("R7", "data stored while stretching", d, 8'h81);
        reg_write(3'd4, 8'h04);
        reg_write(3'd3, 8'h03);
        wait_cyc(4);
        bus_stop();
        reg_write(3'd3, 8'h00);
    endtask

    task automatic t_read();
        logic [7:0] d;
        logic a;
        reg_write(3'd3, 8'h00);
        bus_start();
        send_byte(8'hA1, a);
        chk("R9", "read address ack", a, 1);
        wait_cyc(HP);
        chk("R9", "hold despite stretch off", scl_pull, 1);
        reg_read(3'd4, d);
        chk("R9", "status full+irq+rw", d, 8'h0D);
        reg_read(3'd0, d);
        reg_write(3'd4, 8'h04);
        reg_write(3'd0, 8'hC5);
        reg_write(3'd3, 8'h02);
        recv_byte(1'b1, d);
        chk("R9", "first byte shifted out", d, 8'hC5);
        wait_cyc(HP);
        chk("R10", "hold after master ack", scl_pull, 1);
        chk("R10", "irq after read byte", irq, 1);
        reg_write(3'd4, 8'h04);
        reg_write(3'd0, 8'h3A);
        reg_write(3'd3, 8'h02);
        recv_byte(1'b0, d);
        chk("R10", "second byte shifted out", d, 8'h3A);
        wait_cyc(HP);
        chk("R10", "no hold after nack", scl_pull, 0);
        reg_read(3'd4, d);
        chk("R10", "status reset after nack", d, 8'h00);
        bus_stop();
    endtask

    initial begin
        wait_cyc(5);
        rst_n = 1'b1;
        wait_cyc(3);
        t_reset();
        t_write_basic();
        t_overflow();
        t_mask();
        t_mismatch();
        t_stop();
        t_stretch();
        t_read();
        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog all-requirements actual=timeout expected=finished");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end
endmodule